// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This peripheral holds four identical down-counters that share one interrupt register group. Software reaches the counters through a plain synchronous register port: an address, a write strobe, write data, and read data that follows the address combinationally. A channel gets a start value. It decrements on each tick of its own prescaler and flags an event on the clock edge where its count drops from one to zero. At zero it either parks (one-shot), reloads a stored background value (periodic), or wraps to the all-ones value of its selected width (free-running).

The four zero events go into a raw status vector. Software clears bits by writing ones. A mask selects which raw bits drive the single combined interrupt line. Each channel can count with 32 bits or with only its low 16 bits, and can divide its tick by 1, 16 or 256.

Top module: `mtimer_unit`

## Requirements
- R1: After reset every readable register reads zero, all channels are stopped, and the interrupt output is low.
- R2: Only word-aligned addresses are decoded: shared registers at 0x00 (mask), 0x04 (raw), 0x08 (masked), 0x0C (clear), and channel n at 0x10+0x10·n with load +0x0, count +0x4, control +0x8, background +0xC. Every other address, and the clear register, read zero. Writes to them change nothing.
- R3: Writing the load register sets the count, the background value and the load readback to the written word in one step. Writing the background register changes only the background value.
- R4: An enabled channel (control bit 7) decrements its count by one on every prescaler tick. A disabled channel keeps its count.
- R5: Control bits 3:2 pick the tick divider: 00 gives 1, 01 gives 16, and 10 or 11 give 256. The first tick lands exactly N clock edges after the control write that enables the channel or changes the divider.
- R6: With control bit 1 clear, only the low 16 bits count, the count reads with its upper 16 bits zero, and a free-running wrap goes to 0x0000FFFF. With bit 1 set, the wrap goes to 0xFFFFFFFF.
- R7: With control bit 0 set (one-shot), a count at zero stays at zero until the load register is written.
- R8: With bit 0 clear, a tick at zero reloads the count. It reloads the background value when bit 6 is set, and the all-ones value for the width when bit 6 is clear.
- R9: On the edge where a channel's count goes from 1 to 0, raw status bit n is set. Writing 1 to bit n of the clear register clears it. A new event in the same cycle wins over the clear.
- R10: Masked status equals raw status AND the mask register (bits 3:0). The interrupt output is high exactly when any masked bit is set.
- R11: The control register reads back bits 0, 1, 3:2, 6 and 7 as written. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Combined interrupt, OR of the masked status bits |

## Verification
A register write takes effect on the rising edge that samples it. Read data and the interrupt line reflect that edge at once, because the read path and the interrupt OR are combinational. With divider N, an enabling control write at edge E produces its first decrement at edge E+N, and the raw status bit rises on the same edge that the count reaches zero. The bench drives every access on the falling edge and samples one nanosecond later. Its cycle-level reference model advances on the same rising edges, so each comparison sees the state of exactly the edge just taken. Directed reads compare against literal values worked out from these edge counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic [1:0] psc;
    logic       wide;
    logic       oneshot;
  } ctl_t;

  localparam logic [1:0] REG_LOAD = 2'd0;
  localparam logic [1:0] REG_CUR  = 2'd1;
  localparam logic [1:0] REG_CTL  = 2'd2;
  localparam logic [1:0] REG_BG   = 2'd3;

  localparam logic [1:0] SH_MASK  = 2'd0;
  localparam logic [1:0] SH_RAW   = 2'd1;
  localparam logic [1:0] SH_MIS   = 2'd2;
  localparam logic [1:0] SH_CLR   = 2'd3;

  function automatic ctl_t unpack_ctl(input logic [7:0] w);
    ctl_t c;
    c.en       = w[7];
    c.periodic = w[6];
    c.psc      = w[3:2];
    c.wide     = w[1];
    c.oneshot  = w[0];
    return c;
  endfunction

  function automatic logic [7:0] pack_ctl(input ctl_t c);
    return {c.en, c.periodic, 2'b00, c.psc, c.wide, c.oneshot};
  endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] code,
  output logic       tick
);

  localparam int PSC_W = (DIV_HIGH > 1) ? $clog2(DIV_HIGH) : 1;
  localparam logic [PSC_W-1:0] LIM_MID  = PSC_W'(DIV_MID - 1);
  localparam logic [PSC_W-1:0] LIM_HIGH = PSC_W'(DIV_HIGH - 1);

  logic [PSC_W-1:0] pcnt_q, pcnt_d, lim;

  always_comb begin
    case (code)
      2'b00:   lim = '0;
      2'b01:   lim = LIM_MID;
      default: lim = LIM_HIGH;
    endcase
  end

  assign tick = run && !restart && (pcnt_q == lim);

  always_comb begin
    if (!run || restart || tick) pcnt_d = '0;
    else                         pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R5: while running undisturbed the divider count never passes its limit
  assert_pcnt_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart) |-> (pcnt_q <= lim));

  // R5: a restart always leaves the divider at its first phase
  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pcnt_q == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_reg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_reg,
  output logic [DATA_W-1:0] rd_data,
  output logic              zero_evt
);

  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  ctl_t              ctl_q, ctl_d, new_ctl;
  logic [DATA_W-1:0] cnt_q, cnt_d, bg_q, bg_d, ld_q, ld_d;
  logic [DATA_W-1:0] eff, wrap_val;
  logic              wr_load, wr_ctl, wr_bg, restart, tick, evt;

  assign wr_load = wr_en && (wr_reg == REG_LOAD);
  assign wr_ctl  = wr_en && (wr_reg == REG_CTL);
  assign wr_bg   = wr_en && (wr_reg == REG_BG);
  assign new_ctl = unpack_ctl(wr_data[7:0]);

  assign restart = wr_ctl && ((new_ctl.psc != ctl_q.psc) ||
                              (new_ctl.en && !ctl_q.en));

  assign eff      = ctl_q.wide ? cnt_q : (cnt_q & NARROW_MASK);
  assign wrap_val = ctl_q.wide ? '1 : NARROW_MASK;

  tmr_prescale #(
    .DIV_MID (DIV_MID),
    .DIV_HIGH(DIV_HIGH)
  ) u_psc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctl_q.en),
    .restart(restart),
    .code   (ctl_q.psc),
    .tick   (tick)
  );

  always_comb begin
    ctl_d = ctl_q;
    cnt_d = cnt_q;
    bg_d  = bg_q;
    ld_d  = ld_q;
    evt   = 1'b0;
    if (wr_ctl) ctl_d = new_ctl;
    if (wr_bg)  bg_d  = wr_data;
    if (wr_load) begin
      cnt_d = wr_data;
      bg_d  = wr_data;
      ld_d  = wr_data;
    end else if (ctl_q.en && tick) begin
      if (eff == '0) begin
        if (!ctl_q.oneshot) cnt_d = ctl_q.periodic ? bg_q : wrap_val;
      end else begin
        cnt_d = eff - ONE;
        evt   = (eff == ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
      bg_q  <= '0;
      ld_q  <= '0;
    end else begin
      ctl_q <= ctl_d;
      cnt_q <= cnt_d;
      bg_q  <= bg_d;
      ld_q  <= ld_d;
    end
  end

  always_comb begin
    case (rd_reg)
      REG_LOAD: rd_data = ld_q;
      REG_CUR:  rd_data = eff;
      REG_CTL:  rd_data = {{(DATA_W-8){1'b0}}, pack_ctl(ctl_q)};
      default:  rd_data = bg_q;
    endcase
  end

  assign zero_evt = evt;

  // R4: a stopped channel keeps its count unless loaded
  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !wr_load) |=> $stable(cnt_q));

  // R4: a tick on a count above one takes exactly one away
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && tick && !wr_load && (eff > ONE)) |=> (cnt_q == $past(eff) - ONE));

  // R7: a one-shot channel parked at zero stays there until loaded
  assert_oneshot_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.oneshot && !wr_ctl && (cnt_q == '0) && !wr_load) |=> (cnt_q == '0));

  // R8: a periodic wrap takes the background value
  assert_periodic_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && tick && !wr_load && (eff == '0) && !ctl_q.oneshot && ctl_q.periodic)
      |=> (cnt_q == $past(bg_q)));

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_bits,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_bits,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] raw_q,
  output logic           irq
);

  logic [NCH-1:0] mask_d, raw_d, clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  always_comb begin
    raw_d  = (raw_q & ~clr_eff) | evt;
    mask_d = mask_we ? mask_bits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign irq = |(raw_q & mask_q);

  // R9: every zero event shows up in raw status one edge later
  assert_evt_sets_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt)));

  // R9: cleared bits without a competing event are gone after the edge
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((raw_q & $past(clr_bits & ~evt)) == '0));

endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
  import tmr_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int PAGE_W = ADDR_W - 4;

  logic              rst_meta, rst_core;
  logic [PAGE_W-1:0] page;
  logic [1:0]        sub;
  logic              word_ok, shared_sel;
  logic [NCH-1:0]    evt, mask_q, raw_q;
  logic [DATA_W-1:0] ch_rd [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_core <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_core <= rst_meta;
    end
  end

  assign page       = bus_addr[ADDR_W-1:4];
  assign sub        = bus_addr[3:2];
  assign word_ok    = (bus_addr[1:0] == 2'b00);
  assign shared_sel = word_ok && (page == '0);

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic ch_we;
      assign ch_we = bus_we && word_ok && (page == PAGE_W'(i + 1));
      tmr_channel #(
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W),
        .DIV_MID (DIV_MID),
        .DIV_HIGH(DIV_HIGH)
      ) u_ch (
        .clk     (clk),
        .rst_n   (rst_core),
        .wr_en   (ch_we),
        .wr_reg  (sub),
        .wr_data (bus_wdata),
        .rd_reg  (sub),
        .rd_data (ch_rd[i]),
        .zero_evt(evt[i])
      );
    end
  endgenerate

  tmr_irq #(.NCH(NCH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_core),
    .evt      (evt),
    .mask_we  (bus_we && shared_sel && (sub == SH_MASK)),
    .mask_bits(bus_wdata[NCH-1:0]),
    .clr_we   (bus_we && shared_sel && (sub == SH_CLR)),
    .clr_bits (bus_wdata[NCH-1:0]),
    .mask_q   (mask_q),
    .raw_q    (raw_q),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (shared_sel) begin
      case (sub)
        SH_MASK: bus_rdata = {{(DATA_W-NCH){1'b0}}, mask_q};
        SH_RAW:  bus_rdata = {{(DATA_W-NCH){1'b0}}, raw_q};
        SH_MIS:  bus_rdata = {{(DATA_W-NCH){1'b0}}, raw_q & mask_q};
        default: bus_rdata = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (word_ok && (page == PAGE_W'(i + 1))) bus_rdata = ch_rd[i];
    end
  end

  // R2: addresses beyond the last channel, misaligned ones and the clear register read zero
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_core)
    ((page > PAGE_W'(NCH)) || !word_ok || (shared_sel && (sub == SH_CLR)))
      |-> (bus_rdata == '0));

  // R10: the interrupt line is never high with an empty masked status
  assert_irq_needs_cause_R10: assert property (@(posedge clk) disable iff (!rst_core)
    irq |-> ((raw_q & mask_q) != '0));

endmodule

// File: tb/mtimer_unit_test.sv
`timescale 1ns/1ps
module mtimer_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  b_addr = 8'h00;
  logic        b_we = 1'b0;
  logic [31:0] b_wdata = 32'h0;
  wire  [31:0] b_rdata;
  wire         irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mtimer_unit uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (b_addr),
    .bus_we   (b_we),
    .bus_wdata(b_wdata),
    .bus_rdata(b_rdata),
    .irq      (irq_o)
  );

  // reference model, stepped on the same rising edges
  logic [31:0] m_cnt [4];
  logic [31:0] m_bg  [4];
  logic [31:0] m_ld  [4];
  logic [7:0]  m_ctl [4];
  int          m_pc  [4];
  logic [3:0]  m_raw, m_mask;

  always @(posedge clk or negedge rst_n) begin
    logic       sel, ld, wc, wb, en, tk, rs, aok;
    logic [7:0] nc;
    logic [31:0] e;
    logic [3:0] ev;
    int lim;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_cnt[c] = 0; m_bg[c] = 0; m_ld[c] = 0; m_ctl[c] = 0; m_pc[c] = 0;
      end
      m_raw = 0; m_mask = 0;
    end else begin
      ev  = 4'h0;
      aok = (b_addr[1:0] == 2'b00);
      for (int c = 0; c < 4; c++) begin
        sel = b_we && aok && (b_addr[7:4] == 4'(c + 1));
        ld  = sel && (b_addr[3:2] == 2'd0);
        wc  = sel && (b_addr[3:2] == 2'd2);
        wb  = sel && (b_addr[3:2] == 2'd3);
        nc  = b_wdata[7:0] & 8'hCF;
        en  = m_ctl[c][7];
        lim = (m_ctl[c][3:2] == 2'd0) ? 0 : (m_ctl[c][3:2] == 2'd1) ? 15 : 255;
        rs  = wc && ((nc[3:2] != m_ctl[c][3:2]) || (nc[7] && !en));
        tk  = en && !rs && (m_pc[c] == lim);
        e   = m_ctl[c][1] ? m_cnt[c] : (m_cnt[c] & 32'h0000FFFF);
        if (!en || rs || tk) m_pc[c] = 0; else m_pc[c] = m_pc[c] + 1;
        if (ld) begin
          m_cnt[c] = b_wdata; m_bg[c] = b_wdata; m_ld[c] = b_wdata;
        end else if (tk) begin
          if (e == 0) begin
            if (!m_ctl[c][0])
              m_cnt[c] = m_ctl[c][6] ? m_bg[c] : (m_ctl[c][1] ? 32'hFFFFFFFF : 32'h0000FFFF);
          end else begin
            m_cnt[c] = e - 1;
            if (e == 1) ev[c] = 1'b1;
          end
        end
        if (wb) m_bg[c] = b_wdata;
        if (wc) m_ctl[c] = nc;
      end
      if (b_we && b_addr == 8'h0C) m_raw = m_raw & ~b_wdata[3:0];
      m_raw = m_raw | ev;
      if (b_we && b_addr == 8'h00) m_mask = b_wdata[3:0];
    end
  end

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int c;
    if (a[1:0] != 2'b00) return 32'h0;
    if (a[7:4] == 4'h0) begin
      case (a[3:2])
        2'd0: return {28'h0, m_mask};
        2'd1: return {28'h0, m_raw};
        2'd2: return {28'h0, m_raw & m_mask};
        default: return 32'h0;
      endcase
    end
    if (a[7:4] > 4'h4) return 32'h0;
    c = int'(a[7:4]) - 1;
    case (a[3:2])
      2'd0: return m_ld[c];
      2'd1: return m_ctl[c][1] ? m_cnt[c] : (m_cnt[c] & 32'h0000FFFF);
      2'd2: return {24'h0, m_ctl[c]};
      default: return m_bg[c];
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a[1:0] != 2'b00 || a[7:4] > 4'h4) return "R2";
    if (a[7:4] == 4'h0) begin
      case (a[3:2])
        2'd1: return "R9";
        2'd3: return "R2";
        default: return "R10";
      endcase
    end
    case (a[3:2])
      2'd1: return "R4";
      2'd2: return "R11";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    b_addr = a; b_we = 1'b1; b_wdata = d;
    @(negedge clk);
    b_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, output logic [31:0] v);
    @(negedge clk);
    b_we = 1'b0; b_addr = a;
    #1;
    v = b_rdata;
    check(b_rdata, exp_read(a), tag);
    check({31'h0, irq_o}, {31'h0, |(m_raw & m_mask)}, "R10");
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7321));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: everything reads zero after reset
    for (int a = 0; a < 16'h50; a += 4) begin
      rd(8'(a), "R1", v);
      check(v, 32'h0, "R1");
    end
    check({31'h0, irq_o}, 32'h0, "R1");

    // R2: unmapped and misaligned addresses
    rd(8'h50, "R2", v); check(v, 32'h0, "R2");
    rd(8'hF0, "R2", v); check(v, 32'h0, "R2");
    wr(8'h20, 32'h11);
    rd(8'h21, "R2", v); check(v, 32'h0, "R2");
    wr(8'h22, 32'h99);
    rd(8'h20, "R2", v); check(v, 32'h11, "R2");

    // R3: load sets count and background, background write alone
    wr(8'h30, 32'd100);
    rd(8'h34, "R3", v); check(v, 32'd100, "R3");
    rd(8'h3C, "R3", v); check(v, 32'd100, "R3");
    wr(8'h3C, 32'd55);
    rd(8'h34, "R3", v); check(v, 32'd100, "R3");
    rd(8'h3C, "R3", v); check(v, 32'd55, "R3");

    // R4: divide by one, ten ticks
    wr(8'h38, 32'h82);
    idle(9);
    rd(8'h34, "R4", v); check(v, 32'd90, "R4");
    wr(8'h38, 32'h02);
    rd(8'h34, "R4", v);
    idle(20);
    begin
      logic [31:0] v2;
      rd(8'h34, "R4", v2); check(v2, v, "R4");
    end

    // R5: divide by 16, five ticks in 80 edges
    wr(8'h10, 32'd1000);
    wr(8'h18, 32'h86);
    idle(80);
    rd(8'h14, "R5", v); check(v, 32'd995, "R5");
    wr(8'h18, 32'h8E);
    idle(255);
    rd(8'h14, "R5", v); check(v, 32'd994, "R5");
    wr(8'h18, 32'h02);

    // R6: narrow counting and narrow free-running wrap
    wr(8'h20, 32'h00012345);
    wr(8'h28, 32'h00);
    rd(8'h24, "R6", v); check(v, 32'h00002345, "R6");
    wr(8'h20, 32'd2);
    wr(8'h28, 32'h80);
    idle(2);
    rd(8'h24, "R6", v); check(v, 32'h0000FFFF, "R6");
    wr(8'h28, 32'h00);
    wr(8'h20, 32'd1);
    wr(8'h28, 32'h82);
    idle(1);
    rd(8'h24, "R6", v); check(v, 32'hFFFFFFFF, "R6");
    wr(8'h28, 32'h00);

    // R7: one-shot parks at zero
    wr(8'h40, 32'd3);
    wr(8'h48, 32'h83);
    idle(20);
    rd(8'h44, "R7", v); check(v, 32'h0, "R7");
    rd(8'h04, "R7", v); check(v & 32'h8, 32'h8, "R7");
    wr(8'h40, 32'd5);
    rd(8'h44, "R7", v); check(v, 32'd4, "R7");
    wr(8'h48, 32'h00);

    // R9: clear by writing ones
    wr(8'h0C, 32'hF);
    rd(8'h04, "R9", v); check(v, 32'h0, "R9");

    // R8: periodic reload from background
    wr(8'h10, 32'd3);
    wr(8'h1C, 32'd7);
    wr(8'h18, 32'hC2);
    idle(4);
    rd(8'h14, "R8", v); check(v, 32'd6, "R8");

    // R10: mask gates the interrupt line
    wr(8'h00, 32'h1);
    rd(8'h08, "R10", v); check(v, 32'h1, "R10");
    check({31'h0, irq_o}, 32'h1, "R10");
    wr(8'h00, 32'h0);
    rd(8'h08, "R10", v); check(v, 32'h0, "R10");
    check({31'h0, irq_o}, 32'h0, "R10");
    wr(8'h18, 32'h00);

    // R11: control readback keeps only defined bits
    wr(8'h28, 32'h0000003F);
    rd(8'h28, "R11", v); check(v, 32'h0F, "R11");
    wr(8'h28, 32'hFFFFFF7F);
    rd(8'h28, "R11", v); check(v, 32'h4F, "R11");
    wr(8'h28, 32'h00);

    // mixed random traffic against the model
    for (int i = 0; i < 2500; i++) begin
      int op, ch;
      logic [7:0] base, cw;
      op   = int'($urandom % 10);
      ch   = int'($urandom % 4);
      base = 8'(8'h10 + 8'(ch * 16));
      case (op)
        0: wr(base, ($urandom % 8 == 0) ? (32'h00010000 | ($urandom % 6)) : ($urandom % 40));
        1: wr(base + 8'hC, $urandom % 30);
        2: begin
          cw = 8'($urandom);
          if ($urandom % 6 != 0) cw[3:2] = 2'b00;
          wr(base + 8'h8, {24'h0, cw});
        end
        3: wr(8'h00, $urandom % 16);
        4: wr(8'h0C, $urandom % 16);
        default: begin
          logic [7:0] a;
          a = 8'(($urandom % 22) * 4);
          if ($urandom % 20 == 0) a = a | 8'h2;
          rd(a, tag_of(a), v);
        end
      endcase
      idle(int'($urandom % 3));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule